// File: doc/BRIEF.md
# Reloadable Down-Counting PWM Timer Channel

This block is a single timer channel paced by a one-cycle tick enable. Software-side logic outside the block writes a count buffer, a compare buffer and a four-bit control nibble. The channel copies the count buffer into its working counter when asked. While running, it decrements that counter once per tick. When the counter expires, the channel emits a one-cycle strobe. It then either reloads from the count buffer and keeps going, or stops itself and clears its own start bit.

The working counter is visible on its own output, separate from the two buffers, so an observer can read the live count at any time. A pulse-width output compares the live count against the compare buffer and can be inverted. Address decoding and interrupt collection belong to the surrounding logic. The parameter `HAS_OUTPUT` set to 0 builds the variant that has no waveform output, with no compare buffer and no inverter.

All pins are plain control and status signals. The block has no streaming interface, so it needs no back-pressure rules. Each write enable is taken in the cycle it is high.

Top module: `pwm_timer_channel`

## Requirements
- R1: After reset, the count buffer, the compare buffer, the control nibble and the live counter are all zero, and `expire_o` is low.
- R2: A buffer write updates `cnt_buf_o` or `cmp_buf_o` on the next cycle and leaves `count_o` unchanged.
- R3: The control nibble is encoded as bit 0 = start, bit 1 = manual update, bit 2 = invert and bit 3 = auto-reload. A control write that moves manual update from 0 to 1 copies the count buffer into the counter. A write that leaves manual update at 1 does not load.
- R4: While the start bit is 1, each tick lowers a nonzero counter by one. Without a tick, or with start at 0, the counter holds.
- R5: A tick that finds the counter at zero while start is 1 raises `expire_o` for the following cycle. This repeats on every such tick.
- R6: On expiry with auto-reload set, the counter takes the count buffer value and start stays 1.
- R7: On expiry with auto-reload clear, the counter stays at zero and the start bit in `ctrl_o` clears by itself.
- R8: A tick in the same cycle as a control write is dropped. The new control value and any manual load take effect instead.
- R9: `pwm_o` is 0 while `count_o` is greater than `cmp_buf_o` and 1 otherwise, XORed with the invert bit.
- R10: With `HAS_OUTPUT` = 0, `pwm_o` is 0, the invert bit always reads 0 and `cmp_buf_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count enable, one cycle per count step |
| cnt_wr_en_i | input | 1 | Write strobe for the count buffer |
| cnt_wdata_i | input | CNT_W | Count buffer write value |
| cmp_wr_en_i | input | 1 | Write strobe for the compare buffer |
| cmp_wdata_i | input | CNT_W | Compare buffer write value |
| ctrl_we_i | input | 1 | Write strobe for the control nibble |
| ctrl_wdata_i | input | 4 | Control nibble write value |
| cnt_buf_o | output | CNT_W | Count buffer contents |
| cmp_buf_o | output | CNT_W | Compare buffer contents |
| ctrl_o | output | 4 | Current control nibble, including self-cleared start |
| count_o | output | CNT_W | Live counter value |
| pwm_o | output | 1 | Compare-derived waveform |
| expire_o | output | 1 | One-cycle expiry strobe |

## Verification
The main stimulus is a sequence of control writes interleaved with ticks, gaps with no tick, and ticks that collide with writes. Comparing the counter across these cases separates pacing by ticks from free running, and separates a dropped tick from a counted one. Auto-reload runs are contrasted with one-shot runs: the first must restart from the buffer, and the second must park at zero with start cleared. Rewriting manual update while it is already set shows that loading follows the edge rather than the level. A zero-length period and an all-ones count probe the expiry and compare boundaries.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  localparam int CTRL_W = 4;

  // Field order fixes the nibble encoding: bit3..bit0
  typedef struct packed {
    logic arl;    // auto-reload
    logic inv;    // output invert
    logic mupd;   // manual update
    logic start;  // run
  } chan_ctrl_t;
endpackage

// File: rtl/pwm_chan_ctrl.sv
module pwm_chan_ctrl
  import pwm_chan_pkg::*;
#(
  parameter bit HAS_INV = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              self_stop,
  output chan_ctrl_t        ctrl_q,
  output logic              load_p
);
  chan_ctrl_t wr_val;

  always_comb begin
    wr_val = chan_ctrl_t'(wdata);
    if (!HAS_INV) wr_val.inv = 1'b0;
  end

  // Edge of manual update against the stored value
  assign load_p = we && wr_val.mupd && !ctrl_q.mupd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (we) begin
      ctrl_q <= wr_val;
    end else if (self_stop) begin
      ctrl_q.start <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_chan_counter.sv
module pwm_chan_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             hold,
  input  logic             load,
  input  logic             run,
  input  logic             arl,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count_q,
  output logic             expire_q,
  output logic             self_stop
);
  logic step;
  logic at_zero;

  assign step      = tick && !hold && run;
  assign at_zero   = (count_q == '0);
  assign self_stop = step && at_zero && !arl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q  <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= step && at_zero;
      if (load) begin
        count_q <= reload_val;
      end else if (step) begin
        if (!at_zero)  count_q <= count_q - 1'b1;
        else if (arl)  count_q <= reload_val;
      end
    end
  end
endmodule

// File: rtl/pwm_chan_compare.sv
module pwm_chan_compare #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] cmp,
  input  logic             inv,
  output logic             pwm
);
  logic above;
  assign above = (count > cmp);
  assign pwm   = (~above) ^ inv;
endmodule

// File: rtl/pwm_timer_channel.sv
module pwm_timer_channel
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter bit HAS_OUTPUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              cnt_wr_en_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  input  logic              cmp_wr_en_i,
  input  logic [CNT_W-1:0]  cmp_wdata_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CNT_W-1:0]  cnt_buf_o,
  output logic [CNT_W-1:0]  cmp_buf_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              pwm_o,
  output logic              expire_o
);
  chan_ctrl_t       ctrl_q;
  logic             load_p;
  logic             self_stop;
  logic [CNT_W-1:0] cnt_buf_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_buf_q <= '0;
    else if (cnt_wr_en_i) cnt_buf_q <= cnt_wdata_i;
  end

  pwm_chan_ctrl #(.HAS_INV(HAS_OUTPUT)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (ctrl_we_i),
    .wdata     (ctrl_wdata_i),
    .self_stop (self_stop),
    .ctrl_q    (ctrl_q),
    .load_p    (load_p)
  );

  pwm_chan_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_i),
    .hold       (ctrl_we_i),
    .load       (load_p),
    .run        (ctrl_q.start),
    .arl        (ctrl_q.arl),
    .reload_val (cnt_buf_q),
    .count_q    (count_o),
    .expire_q   (expire_o),
    .self_stop  (self_stop)
  );

  generate
    if (HAS_OUTPUT) begin : g_out
      logic [CNT_W-1:0] cmp_buf_q;
      always_ff @(posedge clk) begin
        if (!rst_n)           cmp_buf_q <= '0;
        else if (cmp_wr_en_i) cmp_buf_q <= cmp_wdata_i;
      end
      pwm_chan_compare #(.CNT_W(CNT_W)) u_cmp (
        .count (count_o),
        .cmp   (cmp_buf_q),
        .inv   (ctrl_q.inv),
        .pwm   (pwm_o)
      );
      assign cmp_buf_o = cmp_buf_q;
    end else begin : g_no_out
      logic unused_cmp;
      assign unused_cmp = ^{cmp_wr_en_i, cmp_wdata_i};
      assign cmp_buf_o  = '0;
      assign pwm_o      = 1'b0;
    end
  endgenerate

  assign cnt_buf_o = cnt_buf_q;
  assign ctrl_o    = ctrl_q;
endmodule

// File: rtl/pwm_timer_channel_chk.sv
module pwm_timer_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             ctrl_we_i,
  input logic [3:0]       ctrl_wdata_i,
  input logic [CNT_W-1:0] cnt_buf_o,
  input logic [3:0]       ctrl_o,
  input logic [CNT_W-1:0] count_o,
  input logic             expire_o
);
  // R5: strobe only after a running tick at zero
  a_r5_expire_cause: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> $past(tick_i && !ctrl_we_i && ctrl_o[0] && count_o == '0));

  // R4: no tick and no write keeps the counter
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !ctrl_we_i) |=> $stable(count_o));

  // R4: running tick on nonzero count steps down by one
  a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !ctrl_we_i && ctrl_o[0] && count_o != '0)
      |=> count_o == CNT_W'($past(count_o) - 1'b1));

  // R6: auto-reload expiry restarts from the buffer
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && $past(ctrl_o[3])) |-> (count_o == $past(cnt_buf_o) && ctrl_o[0]));

  // R7: one-shot expiry parks at zero with start cleared
  a_r7_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !$past(ctrl_o[3])) |-> (count_o == '0 && !ctrl_o[0]));

  // R8: a control write without a manual-update edge leaves the counter
  a_r8_write_drops_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we_i && !(ctrl_wdata_i[1] && !ctrl_o[1])) |=> $stable(count_o));
endmodule

bind pwm_timer_channel pwm_timer_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_i       (tick_i),
  .ctrl_we_i    (ctrl_we_i),
  .ctrl_wdata_i (ctrl_wdata_i),
  .cnt_buf_o    (cnt_buf_o),
  .ctrl_o       (ctrl_o),
  .count_o      (count_o),
  .expire_o     (expire_o)
);

// File: tb/test_pwm_timer_channel.sv
module test_pwm_timer_channel;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic cnt_wr_en_i = 1'b0;
  logic [W-1:0] cnt_wdata_i = '0;
  logic cmp_wr_en_i = 1'b0;
  logic [W-1:0] cmp_wdata_i = '0;
  logic ctrl_we_i = 1'b0;
  logic [3:0] ctrl_wdata_i = '0;
  logic [W-1:0] cnt_buf_o, cmp_buf_o, count_o;
  logic [3:0] ctrl_o;
  logic pwm_o, expire_o;

  logic [W-1:0] n_cnt_buf, n_cmp_buf, n_count;
  logic [3:0] n_ctrl;
  logic n_pwm, n_expire;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pwm_timer_channel #(.CNT_W(W), .HAS_OUTPUT(1'b1)) i_pwm_timer_channel (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .cnt_wr_en_i(cnt_wr_en_i), .cnt_wdata_i(cnt_wdata_i),
    .cmp_wr_en_i(cmp_wr_en_i), .cmp_wdata_i(cmp_wdata_i),
    .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i),
    .cnt_buf_o(cnt_buf_o), .cmp_buf_o(cmp_buf_o), .ctrl_o(ctrl_o),
    .count_o(count_o), .pwm_o(pwm_o), .expire_o(expire_o));

  pwm_timer_channel #(.CNT_W(W), .HAS_OUTPUT(1'b0)) i_pwm_timer_channel_noout (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .cnt_wr_en_i(cnt_wr_en_i), .cnt_wdata_i(cnt_wdata_i),
    .cmp_wr_en_i(cmp_wr_en_i), .cmp_wdata_i(cmp_wdata_i),
    .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i),
    .cnt_buf_o(n_cnt_buf), .cmp_buf_o(n_cmp_buf), .ctrl_o(n_ctrl),
    .count_o(n_count), .pwm_o(n_pwm), .expire_o(n_expire));

  // {we, wdata[3:0], tick, exp_count[15:0], exp_pwm, exp_expire, exp_ctrl[3:0]}
  // Start: count 0, cnt_buf 3, cmp_buf 1. Nibble: 1 start, 2 mupd, 4 inv, 8 arl.
  localparam int NV = 21;
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 4'hA, 1'b1, 16'd3, 1'b0, 1'b0, 4'hA}, // R3 load, R8 tick dropped
    {1'b1, 4'h9, 1'b0, 16'd3, 1'b0, 1'b0, 4'h9}, // start with reload
    {1'b0, 4'h0, 1'b1, 16'd2, 1'b0, 1'b0, 4'h9},
    {1'b0, 4'h0, 1'b1, 16'd1, 1'b1, 1'b0, 4'h9}, // R9 equal gives high
    {1'b0, 4'h0, 1'b0, 16'd1, 1'b1, 1'b0, 4'h9}, // no tick holds
    {1'b0, 4'h0, 1'b1, 16'd0, 1'b1, 1'b0, 4'h9},
    {1'b0, 4'h0, 1'b1, 16'd3, 1'b0, 1'b1, 4'h9}, // R6 reload
    {1'b0, 4'h0, 1'b1, 16'd2, 1'b0, 1'b0, 4'h9},
    {1'b1, 4'hD, 1'b1, 16'd2, 1'b1, 1'b0, 4'hD}, // invert on, tick dropped
    {1'b0, 4'h0, 1'b1, 16'd1, 1'b0, 1'b0, 4'hD},
    {1'b0, 4'h0, 1'b1, 16'd0, 1'b0, 1'b0, 4'hD},
    {1'b1, 4'h5, 1'b0, 16'd0, 1'b0, 1'b0, 4'h5}, // one-shot
    {1'b0, 4'h0, 1'b1, 16'd0, 1'b0, 1'b1, 4'h4}, // R7 self stop
    {1'b0, 4'h0, 1'b1, 16'd0, 1'b0, 1'b0, 4'h4}, // stopped
    {1'b1, 4'h6, 1'b0, 16'd3, 1'b1, 1'b0, 4'h6}, // load while stopped
    {1'b0, 4'h0, 1'b1, 16'd3, 1'b1, 1'b0, 4'h6}, // tick ignored when stopped
    {1'b1, 4'h7, 1'b0, 16'd3, 1'b1, 1'b0, 4'h7}, // mupd level, no reload
    {1'b0, 4'h0, 1'b1, 16'd2, 1'b1, 1'b0, 4'h7},
    {1'b1, 4'h6, 1'b0, 16'd2, 1'b1, 1'b0, 4'h6}, // stop
    {1'b0, 4'h0, 1'b1, 16'd2, 1'b1, 1'b0, 4'h6},
    {1'b1, 4'h0, 1'b0, 16'd2, 1'b0, 1'b0, 4'h0}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drive at negedge, let one posedge pass, return at the next negedge
  task automatic cyc(input logic we, input logic [3:0] wd, input logic tk);
    ctrl_we_i = we; ctrl_wdata_i = wd; tick_i = tk;
    @(posedge clk);
    @(negedge clk);
    ctrl_we_i = 1'b0; ctrl_wdata_i = '0; tick_i = 1'b0;
  endtask

  task automatic wr_bufs(input logic [W-1:0] cv, input logic [W-1:0] mv);
    cnt_wr_en_i = 1'b1; cnt_wdata_i = cv;
    cmp_wr_en_i = 1'b1; cmp_wdata_i = mv;
    @(posedge clk);
    @(negedge clk);
    cnt_wr_en_i = 1'b0; cmp_wr_en_i = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual expired expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "count", 32'(count_o), 0);
    chk("R1", "ctrl", 32'(ctrl_o), 0);
    chk("R1", "cnt_buf", 32'(cnt_buf_o), 0);
    chk("R1", "cmp_buf", 32'(cmp_buf_o), 0);
    chk("R1", "expire", 32'(expire_o), 0);

    // R2 buffer write does not touch the counter
    wr_bufs(16'd3, 16'd1);
    chk("R2", "cnt_buf", 32'(cnt_buf_o), 3);
    chk("R2", "cmp_buf", 32'(cmp_buf_o), 1);
    chk("R2", "count", 32'(count_o), 0);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][27], VEC[i][26:23], VEC[i][22]);
      chk("R4", $sformatf("count v%0d", i), 32'(count_o), 32'(VEC[i][21:6]));
      chk("R9", $sformatf("pwm v%0d", i), 32'(pwm_o), 32'(VEC[i][5]));
      chk("R5", $sformatf("expire v%0d", i), 32'(expire_o), 32'(VEC[i][4]));
      chk("R7", $sformatf("ctrl v%0d", i), 32'(ctrl_o), 32'(VEC[i][3:0]));
    end

    // R2 again with counter nonzero
    wr_bufs(16'h1234, 16'h0001);
    chk("R2", "cnt_buf new", 32'(cnt_buf_o), 32'h1234);
    chk("R2", "count kept", 32'(count_o), 2);

    // R10 variant without output: invert forced to 0, no compare buffer
    cyc(1'b1, 4'h4, 1'b0);
    chk("R10", "ctrl inv", 32'(n_ctrl), 0);
    chk("R10", "cmp_buf", 32'(n_cmp_buf), 0);
    chk("R10", "pwm", 32'(n_pwm), 0);
    cyc(1'b1, 4'h0, 1'b0);

    // R5 zero-length period with reload: expiry on every tick
    wr_bufs(16'd0, 16'd0);
    cyc(1'b1, 4'hA, 1'b0);
    chk("R3", "load zero", 32'(count_o), 0);
    cyc(1'b1, 4'h9, 1'b0);
    cyc(1'b0, 4'h0, 1'b1);
    chk("R5", "first expiry", 32'(expire_o), 1);
    chk("R6", "zero reload", 32'(count_o), 0);
    cyc(1'b0, 4'h0, 1'b1);
    chk("R5", "second expiry", 32'(expire_o), 1);
    chk("R6", "still running", 32'(ctrl_o), 9);
    cyc(1'b0, 4'h0, 1'b0);
    chk("R5", "no tick no expiry", 32'(expire_o), 0);
    cyc(1'b1, 4'h0, 1'b0);

    // R9 all-ones boundary
    wr_bufs(16'hFFFF, 16'hFFFF);
    cyc(1'b1, 4'h2, 1'b0);
    chk("R3", "load max", 32'(count_o), 32'hFFFF);
    chk("R9", "max equal", 32'(pwm_o), 1);
    cmp_wr_en_i = 1'b1; cmp_wdata_i = 16'hFFFE;
    @(posedge clk); @(negedge clk);
    cmp_wr_en_i = 1'b0;
    chk("R9", "max above", 32'(pwm_o), 0);
    chk("R4", "stopped hold", 32'(count_o), 32'hFFFF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule